// File: doc/BRIEF.md
# Trap Entry PC Generator

When the pipeline accepts a fault or trap, this block works out where execution continues. Each fault class has its own request line. The block picks one winner by fixed priority. One cycle later it presents a registered new program counter and a one-cycle redirect pulse. The new PC is the privileged-code base plus the vector offset of the winning class.

On the same edge the block updates the exception-address register. It loads the current PC when the winning class forces a restart address or when the PC is word-aligned. Otherwise it keeps its previous value. Classes marked "skip" then add 4 to that value so that the return path resumes after the faulting instruction. Some classes share a vector. Every class has its own saturating occurrence counter, and only the accepted class counts.

Top module: `trap_vector_unit`

## Requirements
- R1: After a synchronous active-low reset, redirect is 0, new_pc is 0, exc_addr is 0 and every counter is 0.
- R2: In the cycle after any request bit is high, new_pc equals pal_base + the vector offset of the winning class, where pal_base and the offset are both sampled in the request cycle.
- R3: The class index (request bit) to vector offset mapping is: 0 reset 0x0001, 1 machine check 0x0401, 2 interrupt 0x0101, 3 instruction access violation 0x0081, 4 instruction-translation miss 0x0181, 5 single data-translation miss 0x0201, 6 double data-translation miss 0x0281, 7 unaligned access 0x0301, 8 data page fault 0x0381, 9 data access violation 0x0381, 10 illegal opcode 0x0481, 11 arithmetic trap 0x0501, 12 integer overflow 0x0501, 13 floating-point disabled 0x0581, 14 privileged call 0x2001.
- R4: When several request bits are high together, the lowest set index wins: reset first, then machine check, then interrupt, then the rest in ascending vector order.
- R5: redirect is high for exactly one cycle after each request cycle and low after a cycle with no request. new_pc holds between redirects.
- R6: On acceptance, exc_addr loads cur_pc when restart_mask[winner] is 1 or when cur_pc[1:0] is 00.
- R7: If skip_mask[winner] is 1, 4 is added to the value chosen by R6 (the captured PC or the held exc_addr).
- R8: An accepted class with cur_pc[1:0] not 00 and restart_mask[winner] 0 leaves exc_addr at its previous value, plus 4 only if the class skips.
- R9: Classes 8 and 9 produce the same new_pc, and so do classes 11 and 12.
- R10: Each acceptance increments only the winner's counter. Counter i sits at fault_counts[i*CNT_W +: CNT_W].
- R11: A counter at its all-ones maximum stays there when its class is accepted again.
- R12: A cycle with no request changes none of new_pc, exc_addr or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 15 | One request bit per fault class |
| cur_pc | input | PC_W | PC of the faulting instruction |
| restart_mask | input | 15 | Per-class force-capture flag |
| skip_mask | input | 15 | Per-class skip-instruction flag |
| pal_base | input | PC_W | Privileged-code base address |
| redirect | output | 1 | One-cycle redirect strobe |
| new_pc | output | PC_W | Registered handler entry PC |
| exc_addr | output | PC_W | Exception-address register |
| fault_counts | output | 15*CNT_W | Per-class saturating counters, packed |

## Verification
The assertions assume reset is held low for at least two clock edges, so every past value they compare against is a reset value. They also assume the inputs change only between clock edges. The bench meets both: it holds reset for several cycles and drives every input on the falling edge through a single driver task. Each stimulus item sets all inputs together, so no request stays high by accident from one item to the next. The masks are set on purpose to reach each capture case: aligned, unaligned, forced restart and skip.

// File: rtl/trap_vector_unit.sv
module trap_vector_unit #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 4,
  localparam int NCLS  = 15,
  localparam int CLS_W = $clog2(NCLS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCLS-1:0]       fault_req,
  input  logic [PC_W-1:0]       cur_pc,
  input  logic [NCLS-1:0]       restart_mask,
  input  logic [NCLS-1:0]       skip_mask,
  input  logic [PC_W-1:0]       pal_base,
  output logic                  redirect,
  output logic [PC_W-1:0]       new_pc,
  output logic [PC_W-1:0]       exc_addr,
  output logic [NCLS*CNT_W-1:0] fault_counts
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CLS_W-1:0] win;
  logic             hit;
  logic [13:0]      vec;
  logic             take_pc;
  logic [PC_W-1:0]  exc_next;
  logic [NCLS-1:0][CNT_W-1:0] cnt;

  assign hit = |fault_req;

  always_comb begin
    win = '0;
    for (int i = NCLS - 1; i >= 0; i--)
      if (fault_req[i]) win = CLS_W'(i);
  end

  always_comb begin
    case (win)
      4'd0:    vec = 14'h0001;
      4'd1:    vec = 14'h0401;
      4'd2:    vec = 14'h0101;
      4'd3:    vec = 14'h0081;
      4'd4:    vec = 14'h0181;
      4'd5:    vec = 14'h0201;
      4'd6:    vec = 14'h0281;
      4'd7:    vec = 14'h0301;
      4'd8,
      4'd9:    vec = 14'h0381;
      4'd10:   vec = 14'h0481;
      4'd11,
      4'd12:   vec = 14'h0501;
      4'd13:   vec = 14'h0581;
      default: vec = 14'h2001;
    endcase
  end

  assign take_pc  = restart_mask[win] || (cur_pc[1:0] == 2'b00);
  assign exc_next = (take_pc ? cur_pc : exc_addr) + (skip_mask[win] ? PC_W'(4) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect <= 1'b0;
      new_pc   <= '0;
      exc_addr <= '0;
    end else begin
      redirect <= hit;
      if (hit) begin
        new_pc   <= pal_base + PC_W'(vec);
        exc_addr <= exc_next;
      end
    end
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (hit && win == CLS_W'(g) && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign fault_counts = cnt;
endmodule

// File: rtl/trap_vector_unit_chk.sv
module trap_vector_unit_chk #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 4,
  localparam int NCLS = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCLS-1:0]       fault_req,
  input logic                  redirect,
  input logic [PC_W-1:0]       new_pc,
  input logic [PC_W-1:0]       exc_addr,
  input logic [NCLS*CNT_W-1:0] fault_counts
);
  // R5
  redirect_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_req) |=> redirect);

  // R5
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fault_req) |=> !redirect);

  // R12
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fault_req) |=> ($stable(new_pc) && $stable(exc_addr) && $stable(fault_counts)));

  // R10
  one_counter_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fault_counts ^ $past(fault_counts)) <= CNT_W);

  for (genvar g = 0; g < NCLS; g++) begin : g_c
    // R11
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_counts[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}) |=> (fault_counts[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
    // R10
    count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_counts[g*CNT_W +: CNT_W] >= $past(fault_counts[g*CNT_W +: CNT_W]));
  end
endmodule

bind trap_vector_unit trap_vector_unit_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .redirect(redirect),
  .new_pc(new_pc), .exc_addr(exc_addr), .fault_counts(fault_counts)
);

// File: tb/trap_vector_unit_test.sv
`timescale 1ns/1ps
module trap_vector_unit_test;
  localparam int PC_W = 32, CNT_W = 4, NCLS = 15;

  typedef struct {
    logic             redir;
    logic [PC_W-1:0]  npc;
    logic [PC_W-1:0]  exc;
    logic [NCLS*CNT_W-1:0] cnts;
    string            tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [NCLS-1:0] fault_req = '0, restart_mask = '0, skip_mask = '0;
  logic [PC_W-1:0] cur_pc = '0, pal_base = '0;
  logic redirect;
  logic [PC_W-1:0] new_pc, exc_addr;
  logic [NCLS*CNT_W-1:0] fault_counts;

  trap_vector_unit #(.PC_W(PC_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .cur_pc(cur_pc),
    .restart_mask(restart_mask), .skip_mask(skip_mask), .pal_base(pal_base),
    .redirect(redirect), .new_pc(new_pc), .exc_addr(exc_addr), .fault_counts(fault_counts));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];
  logic [PC_W-1:0] m_npc = '0, m_exc = '0;
  logic [CNT_W-1:0] m_cnt [NCLS];

  function automatic logic [PC_W-1:0] vec_of(int c);
    logic [PC_W-1:0] offs [NCLS] = '{32'h0001, 32'h0401, 32'h0101, 32'h0081, 32'h0181,
      32'h0201, 32'h0281, 32'h0301, 32'h0381, 32'h0381, 32'h0481, 32'h0501,
      32'h0501, 32'h0581, 32'h2001};
    return offs[c];
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [NCLS-1:0] req, logic [PC_W-1:0] pc, logic [NCLS-1:0] rm,
                      logic [NCLS-1:0] sm, logic [PC_W-1:0] base, string tag);
    item_t it;
    int w = -1;
    @(negedge clk);
    fault_req = req; cur_pc = pc; restart_mask = rm; skip_mask = sm; pal_base = base;
    for (int i = 0; i < NCLS; i++) if (req[i] && w < 0) w = i;
    if (w >= 0) begin
      m_npc = base + vec_of(w);
      m_exc = ((rm[w] || pc[1:0] == 2'b00) ? pc : m_exc) + (sm[w] ? 32'd4 : 32'd0);
      if (m_cnt[w] != {CNT_W{1'b1}}) m_cnt[w] = m_cnt[w] + 1'b1;
    end
    it.redir = (w >= 0); it.npc = m_npc; it.exc = m_exc; it.tag = tag;
    for (int i = 0; i < NCLS; i++) it.cnts[i*CNT_W +: CNT_W] = m_cnt[i];
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, "redirect", 64'(redirect), 64'(it.redir));
        check(it.tag, "new_pc", 64'(new_pc), 64'(it.npc));
        check(it.tag, "exc_addr", 64'(exc_addr), 64'(it.exc));
        check(it.tag, "counts", 64'(fault_counts), 64'(it.cnts));
      end
    end
  end

  initial begin : watchdog
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    localparam logic [PC_W-1:0] B = 32'h1000_0000;
    for (int i = 0; i < NCLS; i++) m_cnt[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "redirect", 64'(redirect), 64'd0);
    check("R1", "new_pc", 64'(new_pc), 64'd0);
    check("R1", "exc_addr", 64'(exc_addr), 64'd0);
    check("R1", "counts", 64'(fault_counts), 64'd0);

    // R2 R3 R10: each class alone, aligned PC
    for (int c = 0; c < NCLS; c++) begin
      step(NCLS'(1) << c, 32'h0000_4000 + 32'(c * 16), '0, '0, B, "R2_R3_R10");
      step('0, 32'h0000_9990, '0, '0, B, "R5_R12");
    end
    // R9: shared vectors
    step(15'h0100, 32'h0000_5000, '0, '0, 32'h2000_0000, "R9");
    step(15'h0200, 32'h0000_5000, '0, '0, 32'h2000_0000, "R9");
    step(15'h0800, 32'h0000_5100, '0, '0, 32'h2000_0000, "R9");
    step(15'h1000, 32'h0000_5100, '0, '0, 32'h2000_0000, "R9");
    // R4: priority
    step(15'h7fff, 32'h0000_6000, '0, '0, B, "R4");
    step(15'h7ffe, 32'h0000_6004, '0, '0, B, "R4");
    step(15'h7ffc, 32'h0000_6008, '0, '0, B, "R4");
    step(15'h0300, 32'h0000_600c, '0, '0, B, "R4");
    step(15'h4008, 32'h0000_6010, '0, '0, B, "R4");
    // R8: unaligned without restart holds
    step(15'h0080, 32'h0000_7002, '0, '0, B, "R8");
    step(15'h0080, 32'h0000_7003, '0, 15'h0080, B, "R8_R7");
    // R6: forced restart captures unaligned
    step(15'h0080, 32'h0000_7006, 15'h0080, '0, B, "R6");
    // R7: skip on aligned
    step(15'h0800, 32'h0000_8000, '0, 15'h0800, B, "R7");
    step(15'h4000, 32'h0000_8100, 15'h4000, 15'h4000, B, "R7");
    // R12: idle with changing inputs
    step('0, 32'h0000_abcd, 15'h7fff, 15'h7fff, 32'hffff_0000, "R12");
    // R11: saturation of class 0
    for (int k = 0; k < 20; k++) step(15'h0001, 32'h0000_0100, '0, '0, B, "R11");
    step('0, 32'h0, '0, '0, B, "R5_R11");
    step('0, 32'h0, '0, '0, B, "R12");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule